// File: doc/BRIEF.md
# Channel-Status Block Capture Buffer

This block collects the 192 channel-status bits that a digital audio interface receiver carries over one audio block, one bit per frame. Each frame strobe brings one status bit for the first subframe (channel A) and one for the second (channel B). A one-bit source control picks which of the two is kept. A block-start marker, asserted together with the frame strobe of the first frame of a block, begins a new collection.

Bits are gathered in a shadow register. The shadow is copied into a visible 192-bit buffer in the same clock edge that captures the last bit of the block, so a reader never sees a half-updated block. The visible buffer is read as six 32-bit words through a 3-bit word select. Every one of the 192 bits is meaningful, so software may treat the whole buffer as valid.

The sequencer has two states. `S_IDLE` waits for a marked frame. `S_FILL` counts the frames of a block. The transitions are:
- **start**: `S_IDLE` to `S_FILL` on a marked frame.
- **restart**: `S_FILL` to `S_FILL` on a marked frame; the counter goes back to 1.
- **advance**: `S_FILL` to `S_FILL` on an unmarked frame before the last one.
- **complete**: `S_FILL` to `S_IDLE` on the frame carrying bit 191.
- **hold**: an unmarked frame in `S_IDLE` leaves everything unchanged.

Top module: `chsts_capture`

## Requirements
- R1: After reset, `rd_word` reads zero for every `word_sel` value and `blk_done` is low.
- R2: Status bit n of a block (n = 0 for the marked frame, counting frame strobes) lands in byte n/8 at bit position n mod 8. With `word_sel` = k (0 to 5), byte 4k+j appears on `rd_word` bits 8j+7 down to 8j.
- R3: On each frame, `src_sel` = 0 captures `bit_a` and `src_sel` = 1 captures `bit_b`. The select is sampled frame by frame.
- R4: A frame strobe with `blk_start` high is taken as bit 0 of a new block.
- R5: `rd_word` stays unchanged while a block is being collected. The whole visible buffer takes the new block at the clock edge that captures bit 191, and it reads back from the next cycle on.
- R6: `blk_done` is high for exactly the one cycle that follows the edge capturing bit 191.
- R7: A marked frame arriving before bit 191 of the current block discards the partial block. No completion follows from the old block, and collection restarts from bit 0.
- R8: Frame strobes without `blk_start` are ignored while no block is open, both after reset and after a completed block.
- R9: `word_sel` values 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| bit_a | input | 1 | Channel-status bit of subframe A, valid with `frame_stb` |
| bit_b | input | 1 | Channel-status bit of subframe B, valid with `frame_stb` |
| blk_start | input | 1 | Marks the frame that opens a block, qualified by `frame_stb` |
| src_sel | input | 1 | 0 selects channel A, 1 selects channel B |
| word_sel | input | 3 | Selects the 32-bit word shown on `rd_word` |
| rd_word | output | 32 | Selected word of the visible status buffer |
| blk_done | output | 1 | One-cycle pulse after a full block is committed |

## Verification
The visible buffer and `blk_done` are both registered by the same edge that takes bit 191. `rd_word` is a combinational read of that buffer, so a new block and its pulse are due one edge after the strobe of the last frame is driven. A `word_sel` change shows up on `rd_word` in the same cycle, with no edge in between. The bench drives inputs on the falling edge and updates its behavioural model for the rising edge that follows. It compares `rd_word` and `blk_done` at the next falling edge, which places every comparison exactly one registered stage after its stimulus. The word select steps through all eight codes cycle by cycle, so every word and both out-of-range codes are compared across each block.

// File: rtl/chsts_pkg.sv
package chsts_pkg;
    localparam int CS_BLK_BITS = 192;
    localparam int CS_WORD_W   = 32;
    localparam int CS_BYTE_W   = 8;
    localparam int CS_SEL_W    = 3;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_FILL = 1'b1
    } fill_state_t;
endpackage

// File: rtl/chsts_ctrl.sv
module chsts_ctrl
    import chsts_pkg::*;
#(
    parameter int BLK_BITS = CS_BLK_BITS,
    localparam int CNT_W   = $clog2(BLK_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             blk_start,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_idx,
    output logic             commit
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_BITS - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    fill_state_t      state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // next-state and counter
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            S_IDLE: begin
                if (frame_stb && blk_start) begin
                    state_nxt = S_FILL;          // start
                    cnt_nxt   = ONE;
                end
            end
            S_FILL: begin
                if (frame_stb && blk_start) begin
                    cnt_nxt = ONE;               // restart
                end else if (frame_stb) begin
                    if (cnt == LAST) begin
                        state_nxt = S_IDLE;      // complete
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + ONE;     // advance
                    end
                end
            end
            default: begin
                state_nxt = S_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = cnt;
        commit = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (frame_stb && blk_start) begin
                    wr_en  = 1'b1;
                    wr_idx = '0;
                end
            end
            S_FILL: begin
                if (frame_stb) begin
                    wr_en = 1'b1;
                    if (blk_start) begin
                        wr_idx = '0;
                    end else if (cnt == LAST) begin
                        commit = 1'b1;
                    end
                end
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // R4 / R7: a marked frame always reopens a block at bit 1 next
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && blk_start) |=> (state == S_FILL && cnt == ONE));

    // R8: unmarked frames leave an idle sequencer idle
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !(frame_stb && blk_start)) |=> (state == S_IDLE));

    // R2: the bit counter never leaves the block
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/chsts_store.sv
module chsts_store
    import chsts_pkg::*;
#(
    parameter int BLK_BITS = CS_BLK_BITS,
    localparam int CNT_W   = $clog2(BLK_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CNT_W-1:0]    wr_idx,
    input  logic                wr_bit,
    input  logic                commit,
    output logic [BLK_BITS-1:0] vis
);
    logic [BLK_BITS-1:0] shadow, shadow_nxt;

    always_comb begin
        shadow_nxt = shadow;
        if (wr_en) begin
            shadow_nxt[wr_idx] = wr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            vis    <= '0;
        end else begin
            shadow <= shadow_nxt;
            if (commit) begin
                vis <= shadow_nxt;
            end
        end
    end

    // R5: visible copy moves only at a completion edge
    a_r5_vis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(vis));
endmodule

// File: rtl/chsts_rdmux.sv
module chsts_rdmux
    import chsts_pkg::*;
#(
    parameter int BLK_BITS  = CS_BLK_BITS,
    parameter int WORD_W    = CS_WORD_W,
    parameter int BYTE_W    = CS_BYTE_W,
    parameter int SEL_W     = CS_SEL_W,
    localparam int NUM_WORDS = BLK_BITS / WORD_W,
    localparam int BPW       = WORD_W / BYTE_W
) (
    input  logic [BLK_BITS-1:0] vis,
    input  logic [SEL_W-1:0]    sel,
    output logic [WORD_W-1:0]   rd
);
    logic [WORD_W-1:0] words [NUM_WORDS];

    // byte 4k+j of the buffer goes to lane j of word k
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        for (genvar j = 0; j < BPW; j++) begin : g_lane
            assign words[w][j*BYTE_W +: BYTE_W] = vis[(w*BPW + j)*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        rd = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (sel == SEL_W'(w)) begin
                rd = words[w];
            end
        end
    end
endmodule

// File: rtl/chsts_capture.sv
module chsts_capture
    import chsts_pkg::*;
#(
    parameter int BLK_BITS   = CS_BLK_BITS,
    parameter int WORD_W     = CS_WORD_W,
    parameter int SEL_W      = CS_SEL_W,
    localparam int CNT_W     = $clog2(BLK_BITS),
    localparam int NUM_WORDS = BLK_BITS / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              bit_a,
    input  logic              bit_b,
    input  logic              blk_start,
    input  logic              src_sel,
    input  logic [SEL_W-1:0]  word_sel,
    output logic [WORD_W-1:0] rd_word,
    output logic              blk_done
);
    logic                wr_en;
    logic [CNT_W-1:0]    wr_idx;
    logic                commit;
    logic                cap_bit;
    logic [BLK_BITS-1:0] vis;

    assign cap_bit = src_sel ? bit_b : bit_a;

    chsts_ctrl #(.BLK_BITS(BLK_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .blk_start (blk_start),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .commit    (commit)
    );

    chsts_store #(.BLK_BITS(BLK_BITS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_bit (cap_bit),
        .commit (commit),
        .vis    (vis)
    );

    chsts_rdmux #(
        .BLK_BITS (BLK_BITS),
        .WORD_W   (WORD_W),
        .BYTE_W   (CS_BYTE_W),
        .SEL_W    (SEL_W)
    ) u_rdmux (
        .vis (vis),
        .sel (word_sel),
        .rd  (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_done <= 1'b0;
        end else begin
            blk_done <= commit;
        end
    end

    // R6: completion pulse lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    // R9: codes past the last word read zero
    a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_sel >= SEL_W'(NUM_WORDS)) |-> (rd_word == '0));
endmodule

// File: tb/sim_chsts_capture.sv
module sim_chsts_capture;
    localparam int CLK_P = 10;
    localparam int NBITS = 192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic        bit_a = 1'b0;
    logic        bit_b = 1'b0;
    logic        blk_start = 1'b0;
    logic        src_sel = 1'b0;
    logic [2:0]  word_sel = 3'd0;
    logic [31:0] rd_word;
    logic        blk_done;

    always #(CLK_P/2) clk = ~clk;

    chsts_capture u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .blk_start (blk_start),
        .src_sel   (src_sel),
        .word_sel  (word_sel),
        .rd_word   (rd_word),
        .blk_done  (blk_done)
    );

    // behavioural model
    logic [7:0] m_vis [24];
    int         m_q[$];
    bit         m_open = 1'b0;
    bit         m_done = 1'b0;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    ended = 1'b0;
    string cur_tag = "R1";
    int    seed = 17;
    int    sel_ctr = 0;

    function automatic logic [31:0] exp_word(input logic [2:0] s);
        if (s > 3'd5) return 32'h0;
        return {m_vis[4*s+3], m_vis[4*s+2], m_vis[4*s+1], m_vis[4*s]};
    endfunction

    task automatic compare();
        logic [31:0] ew;
        string       t;
        ew = exp_word(word_sel);
        t  = (word_sel > 3'd5) ? "R9" : cur_tag;
        n_chk++;
        if (rd_word !== ew) begin
            n_bad++;
            $display("FAIL %s rd_word sel=%0d actual=%h expected=%h", t, word_sel, rd_word, ew);
        end
        n_chk++;
        if (blk_done !== m_done) begin
            n_bad++;
            $display("FAIL R6/%s blk_done actual=%b expected=%b", cur_tag, blk_done, m_done);
        end
    endtask

    // compare the past edge, then drive and advance the model for the next edge
    task automatic tick(input bit stb, input bit st, input bit a, input bit b,
                        input bit src, input string tag);
        bit v;
        @(negedge clk);
        compare();
        cur_tag   = tag;
        frame_stb = stb;
        blk_start = st;
        bit_a     = a;
        bit_b     = b;
        src_sel   = src;
        word_sel  = 3'(sel_ctr % 8);
        sel_ctr++;
        v = src ? b : a;
        m_done = 1'b0;
        if (rst_n && stb) begin
            if (st) begin
                m_q.delete();
                m_q.push_back(int'(v));
                m_open = 1'b1;
            end else if (m_open) begin
                m_q.push_back(int'(v));
                if (m_q.size() == NBITS) begin
                    for (int n = 0; n < NBITS; n++) m_vis[n/8][n%8] = m_q[n][0];
                    m_done = 1'b1;
                    m_open = 1'b0;
                    m_q.delete();
                end
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // src_mode: 0 = A, 1 = B, 2 = alternate per frame
    task automatic send_bits(input int n, input bit marked, input int src_mode,
                             input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            int  r;
            bit  src;
            r   = $random(seed);
            src = (src_mode == 2) ? bit'(i % 2) : bit'(src_mode);
            tick(1'b1, marked && (i == 0), r[0], r[5], src, tag);
            if (gap > 0) idle(gap, tag);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!ended) begin
            ended = 1'b1;
            n_bad++;
            $display("FAIL R1-watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 24; i++) m_vis[i] = 8'h00;
        // R1: reset state, every select
        idle(4, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle(10, "R1");
        // R8: unmarked frames with no block open
        send_bits(20, 1'b0, 0, 0, "R8");
        // R2 / R4: full block from channel A, back to back
        send_bits(NBITS, 1'b1, 0, 0, "R2");
        idle(10, "R5");
        // R8: after completion, unmarked frames are ignored
        send_bits(30, 1'b0, 1, 1, "R8");
        // R3: full block from channel B, with gaps
        send_bits(NBITS, 1'b1, 1, 1, "R3");
        idle(9, "R5");
        // R7: partial block, then restart
        send_bits(100, 1'b1, 0, 0, "R7");
        send_bits(NBITS, 1'b1, 0, 0, "R7");
        idle(9, "R5");
        // R7: restart one frame before completion
        send_bits(NBITS - 1, 1'b1, 1, 0, "R7");
        send_bits(NBITS, 1'b1, 2, 2, "R3");
        idle(9, "R5");
        // R4: back-to-back blocks, alternating source
        send_bits(NBITS, 1'b1, 2, 0, "R4");
        send_bits(NBITS, 1'b1, 1, 0, "R4");
        idle(12, "R9");
        @(negedge clk);
        compare();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule